// File: doc/BRIEF.md
# Bus-Width Matching FIFO Port Adapter

This block converts between a 72-bit storage word and an external port of 72, 36 or 18 bits. It sits on both sides of a FIFO storage array. On the write side a narrow input stream is packed into complete 72-bit words, which are then offered to storage. On the read side each 72-bit word taken from storage is split into 36-bit or 18-bit slices, one slice per output transfer. Only one direction can be narrow at a time. The legal pairings are 72→72, 72→36, 72→18, 36→72 and 18→72.

All four boundaries use valid/ready handshakes, and one clock runs the whole block. The width pairing and the slice order are sampled from three configuration pins and an endian pin on every clock edge while reset is held low. The sampled values stay fixed until the next reset. With little-endian order the first narrow word takes the least significant end of the wide word. With big-endian order it takes the most significant end.

Top module: `bus_match_adapter`

## Requirements
- R1: While `rst_n` is low the mode is captured on each clock edge. `cfg_match_en`=0 selects 72→72. `cfg_match_en`=1 with `cfg_narrow_in`=1 selects a narrow input: 18 bits if `cfg_quarter`=1, otherwise 36 bits, with a 72-bit output. `cfg_match_en`=1 with `cfg_narrow_in`=0 selects the same widths on the output side, with a 72-bit input.
- R2: Changes on the four configuration pins while `rst_n` is high have no effect on packing or unpacking.
- R3: In 72→72 mode each accepted input word is offered to storage unchanged, and each storage word is presented unchanged on `rd_data`.
- R4: With a narrow input, a wide word is offered on `st_wvalid` only after 2 (36-bit) or 4 (18-bit) narrow writes. Only the low 36 or 18 bits of `wr_data` are used.
- R5: Little-endian (`cfg_big_end`=0): narrow word k, counted from 0 in arrival order, fills bits [k*w +: w] of the wide word, where w is the narrow width. The same placement applies when slicing for output.
- R6: Big-endian (`cfg_big_end`=1): narrow word k fills bits [(n-1-k)*w +: w], where n is 72/w. The same placement applies when slicing for output.
- R7: With a narrow output, `st_rready` is low while a held wide word still has unread slices. It rises in the cycle the last slice is taken, and a new word can be loaded in that same cycle.
- R8: A narrow output slice appears on the low w bits of `rd_data`. The bits above it are zero.
- R9: Reset discards a partially packed word, a partially unpacked word and both slice counters.
- R10: While `st_wvalid` or `rd_valid` is high and its ready is low, the valid stays high and the data stays stable.
- R11: In the first cycle after reset, `st_wvalid` and `rd_valid` are low and `wr_ready` and `st_rready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| cfg_match_en | input | 1 | 1 = one side narrower than 72 bits |
| cfg_narrow_in | input | 1 | 1 = input side narrow, 0 = output side narrow |
| cfg_quarter | input | 1 | Narrow width: 1 = 18 bits, 0 = 36 bits |
| cfg_big_end | input | 1 | 1 = first narrow word at the most significant end |
| wr_valid | input | 1 | Input word valid |
| wr_ready | output | 1 | Input word accepted |
| wr_data | input | 72 | Input word; in narrow modes only the low bits are used |
| st_wvalid | output | 1 | Packed wide word valid toward storage |
| st_wready | input | 1 | Storage accepts the wide word |
| st_wdata | output | 72 | Packed wide word |
| st_rvalid | input | 1 | Storage has a wide word |
| st_rready | output | 1 | Adapter takes the wide word |
| st_rdata | input | 72 | Wide word from storage |
| rd_valid | output | 1 | Output word valid |
| rd_ready | input | 1 | Consumer takes the output word |
| rd_data | output | 72 | Output word; narrow slices are zero-extended |

## Verification
A wrong slice counter on the write side shows up when the storage strobe rises one or more writes too early or too late. A wrong counter on the read side shows up as `st_rready` opening before the last slice, which lets the next word overwrite unread slices. A wrong position mapping is visible at the first offered wide word or the first output slice, as data in the wrong quarter or half. A mode that leaks from the pins after reset shows up at the next transfer as the wrong number of writes per wide word. Every legal pairing is run under both byte orders, so each of these faults appears within a few cycles of reset.

// File: rtl/bm_pkg.sv
// Shared types for the bus-width matching adapter.
// Assumes the wide word is 72 bits and divides into halves and quarters.
package bm_pkg;

    // Number of narrow words per wide word on one side.
    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2
    } ratio_e;

    // Configuration captured during reset.
    typedef struct packed {
        ratio_e in_ratio;
        ratio_e out_ratio;
        logic   big_end;
    } bm_cfg_t;

    // Index of the last narrow word in a wide word.
    function automatic logic [1:0] last_index(ratio_e r);
        case (r)
            RATIO_4: return 2'd3;
            RATIO_2: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // Map the configuration pins onto the per-side ratios.
    function automatic bm_cfg_t decode_cfg(logic match_en, logic narrow_in,
                                           logic quarter, logic big_end);
        bm_cfg_t c;
        ratio_e  narrow_r;
        narrow_r    = quarter ? RATIO_4 : RATIO_2;
        c.in_ratio  = (match_en && narrow_in)  ? narrow_r : RATIO_1;
        c.out_ratio = (match_en && !narrow_in) ? narrow_r : RATIO_1;
        c.big_end   = big_end;
        return c;
    endfunction

endpackage

// File: rtl/bm_cfg_latch.sv
// Captures the width pairing and the slice order while reset is low.
// Assumes synchronous active-low reset; the captured value holds while rst_n is high.
module bm_cfg_latch
    import bm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cfg_match_en,
    input  logic    cfg_narrow_in,
    input  logic    cfg_quarter,
    input  logic    cfg_big_end,
    output bm_cfg_t cfg
);

    bm_cfg_t cfg_q;

    // Sample the pins on every edge while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= decode_cfg(cfg_match_en, cfg_narrow_in, cfg_quarter, cfg_big_end);
        end
    end

    assign cfg = cfg_q;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));

endmodule

// File: rtl/bm_packer.sv
// Write-side packer: gathers 1, 2 or 4 narrow words into one wide word.
// Assumes WIDE_W is divisible by 4. Narrow data sits in the low bits of in_data.
// The wide word is offered only when it is complete.
module bm_packer
    import bm_pkg::*;
#(
    parameter int WIDE_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ratio_e            ratio,
    input  logic              big_end,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WIDE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WIDE_W-1:0] out_data
);

    localparam int HALF_W  = WIDE_W / 2;
    localparam int QUART_W = WIDE_W / 4;

    logic [WIDE_W-1:0] buf_q;
    logic [1:0]        cnt_q;
    logic              full_q;
    logic              last;
    logic              idx2;
    logic [1:0]        idx4;
    logic              accept;

    // Slice position inside the wide word for the current arrival index.
    always_comb begin
        last   = (cnt_q == last_index(ratio));
        idx2   = big_end ? ~cnt_q[0] : cnt_q[0];
        idx4   = big_end ? (2'd3 - cnt_q) : cnt_q;
        accept = in_valid && in_ready;
    end

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = buf_q;

    // Place accepted narrow words and track completion of the wide word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                full_q <= 1'b0;
            end
            if (accept) begin
                case (ratio)
                    RATIO_2: buf_q[HALF_W*int'(idx2) +: HALF_W]   <= in_data[HALF_W-1:0];
                    RATIO_4: buf_q[QUART_W*int'(idx4) +: QUART_W] <= in_data[QUART_W-1:0];
                    default: buf_q <= in_data;
                endcase
                if (last) begin
                    cnt_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 2'd1;
                end
            end
        end
    end

    // R4
    pack_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(accept) && ($past(cnt_q) == last_index(ratio)));

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    pack_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_index(ratio));

    // R11
    pack_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && in_ready));

endmodule

// File: rtl/bm_unpacker.sv
// Read-side unpacker: splits each wide word into 1, 2 or 4 slices.
// Assumes WIDE_W is divisible by 4. A new wide word is taken only once the
// last slice of the held word is consumed, possibly in the same cycle.
module bm_unpacker
    import bm_pkg::*;
#(
    parameter int WIDE_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ratio_e            ratio,
    input  logic              big_end,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WIDE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WIDE_W-1:0] out_data
);

    localparam int HALF_W  = WIDE_W / 2;
    localparam int QUART_W = WIDE_W / 4;

    logic [WIDE_W-1:0] buf_q;
    logic [1:0]        cnt_q;
    logic              hold_q;
    logic              last;
    logic              take;
    logic              idx2;
    logic [1:0]        idx4;

    // Slice selection and the end-of-word condition.
    always_comb begin
        last = (cnt_q == last_index(ratio));
        take = hold_q && out_ready;
        idx2 = big_end ? ~cnt_q[0] : cnt_q[0];
        idx4 = big_end ? (2'd3 - cnt_q) : cnt_q;
        case (ratio)
            RATIO_2: out_data = {{(WIDE_W-HALF_W){1'b0}},  buf_q[HALF_W*int'(idx2) +: HALF_W]};
            RATIO_4: out_data = {{(WIDE_W-QUART_W){1'b0}}, buf_q[QUART_W*int'(idx4) +: QUART_W]};
            default: out_data = buf_q;
        endcase
    end

    assign in_ready  = !hold_q || (take && last);
    assign out_valid = hold_q;

    // Load wide words and step through their slices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            buf_q  <= in_data;
            cnt_q  <= '0;
            hold_q <= 1'b1;
        end else if (take) begin
            if (last) begin
                cnt_q  <= '0;
                hold_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    // R7
    pop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && hold_q) |-> (out_ready && last));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    slice_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != RATIO_1) |-> (out_data[WIDE_W-1:HALF_W] == '0));

    // R11
    unpack_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && in_ready));

endmodule

// File: rtl/bus_match_adapter.sv
// Top of the bus-width matching adapter: reset-captured mode, a write-side
// packer and a read-side unpacker. One clock for both directions.
// Assumes the storage side always uses the full WIDE_W word.
module bus_match_adapter
    import bm_pkg::*;
#(
    parameter int WIDE_W = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_match_en,
    input  logic              cfg_narrow_in,
    input  logic              cfg_quarter,
    input  logic              cfg_big_end,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [WIDE_W-1:0] wr_data,
    output logic              st_wvalid,
    input  logic              st_wready,
    output logic [WIDE_W-1:0] st_wdata,
    input  logic              st_rvalid,
    output logic              st_rready,
    input  logic [WIDE_W-1:0] st_rdata,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [WIDE_W-1:0] rd_data
);

    bm_cfg_t cfg;

    bm_cfg_latch u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_match_en (cfg_match_en),
        .cfg_narrow_in(cfg_narrow_in),
        .cfg_quarter  (cfg_quarter),
        .cfg_big_end  (cfg_big_end),
        .cfg          (cfg)
    );

    bm_packer #(.WIDE_W(WIDE_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio    (cfg.in_ratio),
        .big_end  (cfg.big_end),
        .in_valid (wr_valid),
        .in_ready (wr_ready),
        .in_data  (wr_data),
        .out_valid(st_wvalid),
        .out_ready(st_wready),
        .out_data (st_wdata)
    );

    bm_unpacker #(.WIDE_W(WIDE_W)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio    (cfg.out_ratio),
        .big_end  (cfg.big_end),
        .in_valid (st_rvalid),
        .in_ready (st_rready),
        .in_data  (st_rdata),
        .out_valid(rd_valid),
        .out_ready(rd_ready),
        .out_data (rd_data)
    );

    // R1
    one_narrow_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.in_ratio == RATIO_1) || (cfg.out_ratio == RATIO_1));

endmodule

// File: tb/sim_bus_match_adapter.sv
module sim_bus_match_adapter;

    localparam int W = 72;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n;
    logic         cfg_match_en, cfg_narrow_in, cfg_quarter, cfg_big_end;
    logic         wr_valid, wr_ready, st_wvalid, st_wready;
    logic         st_rvalid, st_rready, rd_valid, rd_ready;
    logic [W-1:0] wr_data, st_wdata, st_rdata, rd_data;

    int n_run  = 0;
    int n_fail = 0;

    bus_match_adapter #(.WIDE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_match_en(cfg_match_en), .cfg_narrow_in(cfg_narrow_in),
        .cfg_quarter(cfg_quarter), .cfg_big_end(cfg_big_end),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .st_wvalid(st_wvalid), .st_wready(st_wready), .st_wdata(st_wdata),
        .st_rvalid(st_rvalid), .st_rready(st_rready), .st_rdata(st_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    // Rows: {match_en, narrow_in, quarter, big_end, seed[7:0]}; all legal pairings x both orders.
    localparam logic [11:0] TBL [10] = '{
        {4'b0000, 8'h11}, {4'b0001, 8'h12},
        {4'b1000, 8'h21}, {4'b1001, 8'h22},
        {4'b1010, 8'h31}, {4'b1011, 8'h32},
        {4'b1100, 8'h41}, {4'b1101, 8'h42},
        {4'b1110, 8'h51}, {4'b1111, 8'h52}
    };

    task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(bit m, bit ni, bit q, bit bg);
        wr_valid = 0; st_wready = 0; st_rvalid = 0; rd_ready = 0;
        wr_data = '0; st_rdata = '0;
        cfg_match_en = m; cfg_narrow_in = ni; cfg_quarter = q; cfg_big_end = bg;
        rst_n = 0;
        tick();
        tick();
        rst_n = 1;
        #1;
    endtask

    function automatic logic [W-1:0] mk(int s, int k);
        logic [31:0] a, b;
        a = 32'(s) * 32'h9E3779B1 + 32'(k) * 32'h7F4A7C15;
        b = ~(32'(s) * 32'h85EBCA6B) ^ (32'(k) * 32'h27D4EB2F);
        return {8'(s + k * 3), a, b};
    endfunction

    // Expected wide word from narrow words mk(s,0..n-1), per R5/R6.
    function automatic logic [W-1:0] wide_pack(int n, bit bg, int s);
        logic [W-1:0] e;
        logic [W-1:0] d;
        int w;
        e = '0;
        w = W / n;
        for (int k = 0; k < n; k++) begin
            int pos;
            pos = bg ? (n - 1 - k) : k;
            d = mk(s, k);
            for (int b = 0; b < w; b++) e[pos * w + b] = d[b];
        end
        return e;
    endfunction

    // Expected output slice k of wide word wd, per R5/R6/R8.
    function automatic logic [W-1:0] slice(logic [W-1:0] wd, int n, bit bg, int k);
        logic [W-1:0] e;
        int w, pos;
        e = '0;
        w = W / n;
        pos = bg ? (n - 1 - k) : k;
        for (int b = 0; b < w; b++) e[b] = wd[pos * w + b];
        return e;
    endfunction

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] wd, wd2, ex;
        rst_n = 0;
        cfg_match_en = 0; cfg_narrow_in = 0; cfg_quarter = 0; cfg_big_end = 0;
        wr_valid = 0; st_wready = 0; st_rvalid = 0; rd_ready = 0;
        wr_data = '0; st_rdata = '0;

        // Table walk: R1 mode decode, R3..R8 and R10 for every pairing and order.
        for (int r = 0; r < 10; r++) begin
            bit m, ni, q, bg;
            int s, nin, nout;
            string rq;
            m = TBL[r][11]; ni = TBL[r][10]; q = TBL[r][9]; bg = TBL[r][8];
            s = int'(TBL[r][7:0]);
            nin  = (m && ni)  ? (q ? 4 : 2) : 1;
            nout = (m && !ni) ? (q ? 4 : 2) : 1;
            do_reset(m, ni, q, bg);
            // R11 reset state
            chk(!st_wvalid && !rd_valid && wr_ready && st_rready, "R11",
                {st_wvalid, rd_valid, wr_ready, st_rready}, 4'b0011);

            // Pack direction.
            for (int k = 0; k < nin; k++) begin
                wr_valid = 1; wr_data = mk(s, k);
                tick();
                if (k < nin - 1) chk(st_wvalid == 0, "R4 early push", st_wvalid, 0);
            end
            wr_valid = 0;
            ex = wide_pack(nin, bg, s);
            rq = (nin == 1) ? "R3" : (bg ? "R6" : "R5");
            chk(st_wvalid == 1, "R1 R4 push after last", st_wvalid, 1);
            chk(st_wdata == ex, rq, st_wdata, ex);
            tick();
            chk(st_wvalid && st_wdata == ex, "R10 write hold", st_wdata, ex);
            st_wready = 1;
            tick();
            chk(st_wvalid == 0, "R10 push taken", st_wvalid, 0);
            st_wready = 0;

            // Unpack direction.
            wd = mk(s, 20); wd2 = mk(s, 21);
            st_rvalid = 1; st_rdata = wd;
            #1;
            chk(st_rready == 1, "R7 empty takes word", st_rready, 1);
            tick();
            st_rdata = wd2;
            #1;
            chk(st_rready == 0, "R7 hold blocks pop", st_rready, 0);
            ex = slice(wd, nout, bg, 0);
            chk(rd_valid && rd_data == ex, "R8 first slice", rd_data, ex);
            tick();
            chk(rd_valid && rd_data == ex, "R10 read hold", rd_data, ex);
            for (int k = 0; k < nout; k++) begin
                rd_ready = 1;
                #1;
                ex = slice(wd, nout, bg, k);
                rq = (nout == 1) ? "R3" : (bg ? "R6 R8" : "R5 R8");
                chk(rd_data == ex, rq, rd_data, ex);
                chk(st_rready == (k == nout - 1), "R7 pop only after last",
                    st_rready, (k == nout - 1));
                tick();
            end
            rd_ready = 0; st_rvalid = 0;
            #1;
            ex = slice(wd2, nout, bg, 0);
            chk(rd_valid && rd_data == ex, "R7 next word", rd_data, ex);
        end

        // R9: partial pack discarded by reset.
        do_reset(1, 1, 1, 0);
        for (int k = 0; k < 2; k++) begin
            wr_valid = 1; wr_data = mk(77, k);
            tick();
        end
        do_reset(1, 1, 1, 0);
        for (int k = 0; k < 4; k++) begin
            wr_valid = 1; wr_data = mk(88, k);
            tick();
            if (k < 3) chk(st_wvalid == 0, "R9 counter cleared", st_wvalid, 0);
        end
        wr_valid = 0;
        ex = wide_pack(4, 0, 88);
        chk(st_wvalid && st_wdata == ex, "R9 fresh word", st_wdata, ex);

        // R9: partial unpack discarded by reset.
        do_reset(1, 0, 1, 1);
        st_rvalid = 1; st_rdata = mk(5, 20);
        tick();
        st_rvalid = 0; rd_ready = 1;
        tick();
        rd_ready = 0;
        do_reset(1, 0, 1, 1);
        chk(rd_valid == 0, "R9 held word dropped", rd_valid, 0);
        wd2 = mk(6, 20);
        st_rvalid = 1; st_rdata = wd2;
        tick();
        st_rvalid = 0;
        #1;
        ex = slice(wd2, 4, 1, 0);
        chk(rd_valid && rd_data == ex, "R9 slice index cleared", rd_data, ex);

        // R2: pins changed after reset have no effect.
        do_reset(1, 1, 0, 0);
        cfg_match_en = 0; cfg_narrow_in = 0; cfg_quarter = 1; cfg_big_end = 1;
        wr_valid = 1; wr_data = mk(99, 0);
        tick();
        chk(st_wvalid == 0, "R2 still packing", st_wvalid, 0);
        wr_data = mk(99, 1);
        tick();
        wr_valid = 0;
        ex = wide_pack(2, 0, 99);
        chk(st_wvalid && st_wdata == ex, "R2 mode and order kept", st_wdata, ex);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule